// File: doc/BRIEF.md
# Cartridge ROM Bank Mapper

This block does the bank switching for an expansion cartridge that holds 16, 32 or 64 KB of ROM, split into banks of 16 KB. It watches four active-low host bus strobes: two ROM window selects and two I/O page selects. It drives the bank number and the in-bank offset to the ROM array. It also drives a ROM drive-enable, which the data bus drivers outside this block use.

A falling edge on the first I/O page strobe moves the bank one step through a fixed sequence chosen by the size. A falling edge on the second I/O page strobe switches the ROM off. The ROM stays off until the next reset. Reads and writes have the same effect, and data values play no part. The size is a static configuration input, and it is sampled while reset is active.

Top module: `cart_bank_mapper`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `bank_o` is 0 and the ROM is enabled.
- R2: `offset_o` equals `addr_i` in the same cycle.
- R3: With `size_i` = 0 (16 KB), `bank_o` stays 0 whatever accesses occur.
- R4: With `size_i` = 1 (32 KB), successive first-page accesses after reset give banks 1, 0, 1, and then 0 from then on.
- R5: With `size_i` = 2 or 3 (64 KB), successive first-page accesses after reset give banks 1, 2, 3, and then 0 from then on.
- R6: An access counts once, on the falling edge of its strobe. The new bank appears on `bank_o` after the next rising clock edge, and a strobe held low for several cycles advances the bank only once.
- R7: A falling edge of `io2_ni` disables the ROM until the next reset. The bank keeps stepping on first-page accesses while the ROM is disabled.
- R8: `rom_oe_o` is high exactly when `roml_ni` or `romh_ni` is low and the ROM is not disabled.
- R9: A falling I/O strobe in a cycle where `roml_ni` or `romh_ni` is low is ignored, because the ROM window has priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| size_i | input | 2 | ROM size: 0 = 16 KB, 1 = 32 KB, 2 or 3 = 64 KB |
| roml_ni | input | 1 | Low ROM window select, active low |
| romh_ni | input | 1 | High ROM window select, active low |
| io1_ni | input | 1 | First I/O page select, active low (bank step) |
| io2_ni | input | 1 | Second I/O page select, active low (ROM off) |
| addr_i | input | 14 | Host address, low bits |
| bank_o | output | 2 | Selected bank |
| offset_o | output | 14 | Offset within the bank |
| rom_oe_o | output | 1 | ROM drive-enable |

## Verification
A ROM window select and a falling I/O page strobe can occur in the same cycle. In that case the ROM window wins and the I/O edge must have no effect. The bench lowers `roml_ni` or `romh_ni` in the same cycle as `io1_ni` falls, then checks that `bank_o` is unchanged. It does the same with `io2_ni` falling under a ROM select, then checks that a later ROM probe still shows `rom_oe_o` high.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int unsigned BANK_W  = 2;
  localparam int unsigned OFF_W   = 14;
  localparam int unsigned STEPS   = 3;
  localparam int unsigned SEQ_W   = BANK_W * STEPS;

  typedef enum logic [1:0] {
    SZ_16K  = 2'd0,
    SZ_32K  = 2'd1,
    SZ_64K  = 2'd2,
    SZ_64KB = 2'd3
  } rom_size_e;
endpackage

// File: rtl/cbm_edge_det.sv
module cbm_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] strb_ni,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= strb_ni;
  end

  for (genvar g = 0; g < N; g++) begin : g_fall
    assign fall_o[g] = prev_q[g] & ~strb_ni[g];
  end
endmodule

// File: rtl/cbm_bank_seq.sv
module cbm_bank_seq
  import cbm_pkg::*;
#(
  parameter int unsigned BW    = BANK_W,
  parameter int unsigned NSTEP = STEPS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    size_i,
  input  logic          step_i,
  output logic [BW-1:0] bank_o
);
  localparam int unsigned SW    = BW * NSTEP;
  localparam int unsigned NBANK = 1 << BW;

  logic [SW-1:0] seed_32, seed_64, seed;
  logic [SW-1:0] seq_q;
  logic [BW-1:0] bank_q;

  for (genvar g = 0; g < NSTEP; g++) begin : g_seed
    assign seed_32[g*BW +: BW] = BW'((g + 1) % 2);
    assign seed_64[g*BW +: BW] = BW'((g + 1) % NBANK);
  end

  always_comb begin
    unique case (rom_size_e'(size_i))
      SZ_16K:  seed = '0;
      SZ_32K:  seed = seed_32;
      default: seed = seed_64;
    endcase
  end

  // low field becomes the bank, zeros shift in from the top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q  <= seed;
      bank_q <= '0;
    end else if (step_i) begin
      seq_q  <= seq_q >> BW;
      bank_q <= seq_q[BW-1:0];
    end
  end

  assign bank_o = bank_q;

  // R3
  small_rom_bank0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'd0) |-> (bank_o == '0));

  // R1
  reset_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (bank_o == '0));
endmodule

// File: rtl/cbm_rom_gate.sv
module cbm_rom_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kill_i,
  input  logic rom_sel_i,
  output logic oe_o
);
  logic off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     off_q <= 1'b0;
    else if (kill_i) off_q <= 1'b1;
  end

  assign oe_o = rom_sel_i & ~off_q;

  // R7
  kill_takes_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> !oe_o);
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        size_i,
  input  logic              roml_ni,
  input  logic              romh_ni,
  input  logic              io1_ni,
  input  logic              io2_ni,
  input  logic [OFF_W-1:0]  addr_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic              rom_oe_o
);
  logic       rom_act;
  logic [1:0] io_fall;
  logic       step_hit, kill_hit;

  assign rom_act = ~(roml_ni & romh_ni);

  cbm_edge_det #(.N(2)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strb_ni ({io2_ni, io1_ni}),
    .fall_o  (io_fall)
  );

  // ROM window wins over I/O decode
  assign step_hit = io_fall[0] & ~rom_act;
  assign kill_hit = io_fall[1] & ~rom_act;

  cbm_bank_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .size_i (size_i),
    .step_i (step_hit),
    .bank_o (bank_o)
  );

  cbm_rom_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kill_i    (kill_hit),
    .rom_sel_i (rom_act),
    .oe_o      (rom_oe_o)
  );

  assign offset_o = addr_i;

  // R6
  held_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io1_ni ##1 !io1_ni ##1 !io1_ni) |-> $stable(bank_o));

  // R9
  rom_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(io1_ni) && !roml_ni) |=> $stable(bank_o));

  // R8
  oe_needs_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (roml_ni && romh_ni) |-> !rom_oe_o);
endmodule

// File: tb/sim_cart_bank_mapper.sv
module sim_cart_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic        roml_ni = 1'b1, romh_ni = 1'b1, io1_ni = 1'b1, io2_ni = 1'b1;
  logic [13:0] addr_i = '0;
  logic [1:0]  bank_o;
  logic [13:0] offset_o;
  logic        rom_oe_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cart_bank_mapper u0 (
    .clk_i(clk), .rst_ni(rst_ni), .size_i(size_i),
    .roml_ni(roml_ni), .romh_ni(romh_ni), .io1_ni(io1_ni), .io2_ni(io2_ni),
    .addr_i(addr_i), .bank_o(bank_o), .offset_o(offset_o), .rom_oe_o(rom_oe_o)
  );

  localparam logic [1:0] OP_RST = 2'd0, OP_IO1 = 2'd1, OP_IO2 = 2'd2;
  // {op, size, exp_bank, exp_oe}
  localparam int NV = 21;
  localparam logic [6:0] VEC [NV] = '{
    {OP_RST, 2'd2, 2'd0, 1'b1},  // R1 R5
    {OP_IO1, 2'd2, 2'd1, 1'b1},
    {OP_IO1, 2'd2, 2'd2, 1'b1},
    {OP_IO1, 2'd2, 2'd3, 1'b1},
    {OP_IO1, 2'd2, 2'd0, 1'b1},
    {OP_IO1, 2'd2, 2'd0, 1'b1},
    {OP_IO2, 2'd2, 2'd0, 1'b0},  // R7
    {OP_IO1, 2'd2, 2'd0, 1'b0},
    {OP_RST, 2'd1, 2'd0, 1'b1},  // R4
    {OP_IO1, 2'd1, 2'd1, 1'b1},
    {OP_IO1, 2'd1, 2'd0, 1'b1},
    {OP_IO1, 2'd1, 2'd1, 1'b1},
    {OP_IO1, 2'd1, 2'd0, 1'b1},
    {OP_RST, 2'd0, 2'd0, 1'b1},  // R3
    {OP_IO1, 2'd0, 2'd0, 1'b1},
    {OP_IO1, 2'd0, 2'd0, 1'b1},
    {OP_RST, 2'd3, 2'd0, 1'b1},  // R5 alt code
    {OP_IO1, 2'd3, 2'd1, 1'b1},
    {OP_IO2, 2'd3, 2'd1, 1'b0},  // R7 bank keeps stepping
    {OP_IO1, 2'd3, 2'd2, 1'b0},
    {OP_IO1, 2'd3, 2'd3, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] sz);
    @(negedge clk);
    rst_ni = 1'b0;
    size_i = sz;
    @(negedge clk);
    chk("R1 bank in reset", 16'(bank_o), 16'd0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic pulse_io(input bit second, input int low_cycles);
    @(negedge clk);
    if (second) io2_ni = 1'b0; else io1_ni = 1'b0;
    repeat (low_cycles) @(negedge clk);
    io1_ni = 1'b1;
    io2_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic probe(input string req, input logic exp_oe, input logic [13:0] a);
    @(negedge clk);
    romh_ni = 1'b0;
    addr_i  = a;
    #1;
    chk(req, 16'(rom_oe_o), 16'(exp_oe));
    chk("R2 offset", 16'(offset_o), 16'(a));
    @(negedge clk);
    romh_ni = 1'b1;
    #1;
    chk("R8 oe idle", 16'(rom_oe_o), 16'd0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op, sz, eb;
      logic eo;
      {op, sz, eb, eo} = VEC[i];
      case (op)
        OP_RST: do_reset(sz);
        OP_IO1: pulse_io(1'b0, 1);
        default: pulse_io(1'b1, 1);
      endcase
      chk("R3 R4 R5 bank", 16'(bank_o), 16'(eb));
      probe("R7 R8 oe", eo, 14'(i * 14'h2a5 + 14'h11));
    end

    // R6: held strobe advances once
    do_reset(2'd2);
    pulse_io(1'b0, 6);
    chk("R6 held low", 16'(bank_o), 16'd1);
    pulse_io(1'b0, 1);
    chk("R6 next edge", 16'(bank_o), 16'd2);

    // R9: io1 edge under ROM select ignored
    @(negedge clk);
    roml_ni = 1'b0; io1_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    roml_ni = 1'b1; io1_ni = 1'b1;
    @(negedge clk);
    chk("R9 io1 under rom", 16'(bank_o), 16'd2);

    // R9: io2 edge under ROM select ignored
    @(negedge clk);
    romh_ni = 1'b0; io2_ni = 1'b0;
    @(negedge clk);
    #1;
    chk("R9 io2 under rom oe", 16'(rom_oe_o), 16'd1);
    @(negedge clk);
    romh_ni = 1'b1; io2_ni = 1'b1;
    probe("R9 oe after io2", 1'b1, 14'h3fff);

    // R7: disable persists until reset, reset restores
    pulse_io(1'b1, 1);
    probe("R7 disabled", 1'b0, 14'h0);
    pulse_io(1'b1, 1);
    probe("R7 still disabled", 1'b0, 14'h1234);
    do_reset(2'd2);
    probe("R1 oe after reset", 1'b1, 14'h2000);
    chk("R1 bank after reset", 16'(bank_o), 16'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule